// File: doc/BRIEF.md
# Bipolar Line Encoder with Test Overrides

This block converts the binary transmit stream of a 1.544 Mbit/s framer into the two rail signals that drive a bipolar line interface. Each bit arrives with a one-cycle bit enable. The block encodes it either as plain alternate mark inversion or with eight-zero substitution, selected by a configuration input. To make the substitution possible, every bit passes through an eight-position delay line. A mark always takes the opposite polarity from the previous pulse. A zero sends no pulse.

Three test controls override the normal code. A rising edge on the violation-insert input arms exactly one polarity violation. The force-LOS input silences the line. The all-ones input, used while the framer loops back locally, sends a continuous stream of alternating marks. By default the block drives dual-rail outputs. A single-rail mode puts every pulse on the positive rail and holds the negative rail low.

Top module: `bipolar_line_encoder`

## Requirements
- R1: While reset is asserted and after it is released, both rails are low until the first bit enable that carries real data reaches the output. The eight delay positions start as fill, which sends no pulse and never counts toward a zero run.
- R2: A bit presented with bit enable k reaches the rails on the clock edge of bit enable k+8. The first eight enables after reset produce no pulse.
- R3: With substitutionOff = 1 (plain alternate mark inversion), each 1 produces a pulse of the opposite polarity to the previous pulse, and each 0 produces no pulse. The first pulse after reset is positive.
- R4: With substitutionOff = 0, every run of eight zeros that have not already been substituted is sent in time order as 0,0,0,V,B,0,V,B. Each V repeats the polarity of the previous pulse. Each B takes the opposite polarity.
- R5: A 0-to-1 transition on violInsert arms one violation. The next alternating pulse (a data mark, a B pulse or an all-ones mark) repeats the previous polarity instead of alternating. Keeping violInsert high arms nothing more.
- R6: When forceLos is 1 at a bit enable, both rails go low. This takes priority over all other controls. The polarity history and any armed violation are left unchanged.
- R7: When allOnes is 1 and forceLos is 0, every bit enable sends an alternating mark, whatever the data and the delay-line contents.
- R8: With singleRail = 1, posRail is 1 for every pulse of either polarity and negRail stays 0. The polarity bookkeeping is the same as in dual-rail mode.
- R9: posRail and negRail are never both 1.
- R10: In a cycle without bit enable, the rails and the encoder state hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | One-cycle strobe that marks a bit period |
| dataIn | input | 1 | Transmit data bit, sampled when bitEn is 1 |
| substitutionOff | input | 1 | 0 selects eight-zero substitution, 1 selects plain alternate mark inversion |
| singleRail | input | 1 | 1 selects single-rail output |
| violInsert | input | 1 | Violation request; each rising edge arms one violation |
| forceLos | input | 1 | Send silence instead of traffic |
| allOnes | input | 1 | Send all ones toward the line |
| posRail | output | 1 | Positive pulse rail, or the pulse-present line in single-rail mode |
| negRail | output | 1 | Negative pulse rail |

## Verification
A violation can be armed at the moment a substitution pattern reaches the output. It is then consumed by the B pulse, and the V pulses of that pattern are left alone. Likewise a force-LOS window can overlap an all-ones window, and while it does the violation stays armed. The sweep drives violation edges, held violation levels and overlapping override windows against data with long zero runs, in both code modes and both rail modes. A model in the bench builds the zero runs from a run counter and replays the polarity history one bit at a time. Every output bit is compared with it, so a violation consumed by the wrong pulse, or an override that changes the polarity history, shows up as a rail mismatch.

// File: rtl/lineenc_pkg.sv
package lineenc_pkg;
  // Length of the substitution window; the pattern itself fixes it at eight.
  localparam int SUB_LEN = 8;
  localparam int IDX_W   = $clog2(SUB_LEN);

  typedef enum logic [2:0] {
    SYM_FILL = 3'd0,  // reset filler, no pulse, not part of a zero run
    SYM_ZERO = 3'd1,  // plain zero
    SYM_MARK = 3'd2,  // data one
    SYM_VIOL = 3'd3,  // substituted V pulse
    SYM_BAL  = 3'd4   // substituted B pulse
  } sym_t;

  typedef struct packed {
    logic advance;   // bit period boundary
    logic sendLos;   // silence the line
    logic sendOnes;  // all-ones override (already masked by LOS)
    logic violate;   // next alternating pulse repeats polarity
  } strobe_t;

  // Substitution symbol for delay position i (0 = newest, SUB_LEN-1 = oldest).
  function automatic sym_t subSymbol(input int i);
    case (i)
      0, 3:    subSymbol = SYM_BAL;
      1, 4:    subSymbol = SYM_VIOL;
      default: subSymbol = SYM_ZERO;
    endcase
  endfunction
endpackage

// File: rtl/lineenc_ctrl.sv
module lineenc_ctrl
  import lineenc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitEn,
  input  logic    violInsert,
  input  logic    forceLos,
  input  logic    allOnes,
  input  logic    altPulse,
  output strobe_t strobe
);
  logic violPrev;
  logic violArmed;
  logic violRise;

  assign violRise = violInsert & ~violPrev;

  always_comb begin
    strobe.advance  = bitEn;
    strobe.sendLos  = forceLos;
    strobe.sendOnes = allOnes & ~forceLos;
    strobe.violate  = violArmed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violPrev  <= 1'b0;
      violArmed <= 1'b0;
    end else begin
      violPrev <= violInsert;
      if (violRise)
        violArmed <= 1'b1;
      else if (bitEn && violArmed && altPulse)
        violArmed <= 1'b0;
    end
  end
endmodule

// File: rtl/lineenc_dp.sv
module lineenc_dp
  import lineenc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobe,
  input  logic    dataIn,
  input  logic    substitutionOff,
  input  logic    singleRail,
  output logic    posRail,
  output logic    negRail,
  output logic    altPulse
);
  sym_t stage [SUB_LEN];
  sym_t head;
  sym_t nextIn;
  logic runComplete;
  logic violPulse;
  logic anyPulse;
  logic pulsePos;
  logic lastPos;

  assign head   = stage[SUB_LEN-1];
  assign nextIn = dataIn ? SYM_MARK : SYM_ZERO;

  // Eight plain zeros once the new bit enters: substitute the whole window.
  always_comb begin
    runComplete = !substitutionOff && (nextIn == SYM_ZERO);
    for (int i = 0; i < SUB_LEN-1; i++)
      if (stage[i] != SYM_ZERO) runComplete = 1'b0;
  end

  always_comb begin
    altPulse  = !strobe.sendLos &&
                (strobe.sendOnes || head == SYM_MARK || head == SYM_BAL);
    violPulse = !strobe.sendLos && !strobe.sendOnes && head == SYM_VIOL;
    anyPulse  = altPulse || violPulse;
    pulsePos  = (altPulse && !strobe.violate) ? ~lastPos : lastPos;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SUB_LEN; i++) stage[i] <= SYM_FILL;
      lastPos <= 1'b0;
      posRail <= 1'b0;
      negRail <= 1'b0;
    end else if (strobe.advance) begin
      if (runComplete) begin
        for (int i = 0; i < SUB_LEN; i++) stage[i] <= subSymbol(i);
      end else begin
        stage[0] <= nextIn;
        for (int i = 1; i < SUB_LEN; i++) stage[i] <= stage[i-1];
      end
      if (anyPulse) lastPos <= pulsePos;
      posRail <= anyPulse && (singleRail || pulsePos);
      negRail <= anyPulse && !singleRail && !pulsePos;
    end
  end
endmodule

// File: rtl/bipolar_line_encoder.sv
module bipolar_line_encoder
  import lineenc_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic dataIn,
  input  logic substitutionOff,
  input  logic singleRail,
  input  logic violInsert,
  input  logic forceLos,
  input  logic allOnes,
  output logic posRail,
  output logic negRail
);
  strobe_t strobe;
  logic    altPulse;

  lineenc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .violInsert(violInsert),
    .forceLos(forceLos), .allOnes(allOnes), .altPulse(altPulse),
    .strobe(strobe)
  );

  lineenc_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .substitutionOff(substitutionOff), .singleRail(singleRail),
    .posRail(posRail), .negRail(negRail), .altPulse(altPulse)
  );
endmodule

// File: rtl/bipolar_line_encoder_chk.sv
module bipolar_line_encoder_chk (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic singleRail,
  input logic forceLos,
  input logic allOnes,
  input logic posRail,
  input logic negRail
);
  AST_RAILS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(posRail && negRail)); // R9

  AST_LOS_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && forceLos) |=> (!posRail && !negRail)); // R6

  AST_ONES_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && allOnes && !forceLos) |=> (posRail || negRail)); // R7

  AST_SINGLE_NEG_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && singleRail) |=> !negRail); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> ($stable(posRail) && $stable(negRail))); // R10

  always @(posedge clk)
    if (!rstN) AST_RESET_QUIET: assert (!posRail && !negRail); // R1
endmodule

bind bipolar_line_encoder bipolar_line_encoder_chk chk_i (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .singleRail(singleRail),
  .forceLos(forceLos), .allOnes(allOnes), .posRail(posRail), .negRail(negRail)
);

// File: tb/bipolar_line_encoder_tb_top.sv
module bipolar_line_encoder_tb_top;
  localparam int STEPS = 64;
  localparam int DLY   = 8;
  // Bench-side symbol codes
  localparam int S_ZERO = 0, S_MARK = 1, S_V = 2, S_B = 3, S_NONE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0, dataIn = 1'b0, substitutionOff = 1'b0, singleRail = 1'b0;
  logic violInsert = 1'b0, forceLos = 1'b0, allOnes = 1'b0;
  logic posRail, negRail;

  int nChecks = 0;
  int nFails  = 0;
  bit done = 0;

  int  symArr [STEPS];
  bit  losArr [STEPS];
  bit  onesArr[STEPS];
  bit  violArr[STEPS];
  bit  dArr   [STEPS];

  always #5 clk = ~clk;

  bipolar_line_encoder dut_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .dataIn(dataIn),
    .substitutionOff(substitutionOff), .singleRail(singleRail),
    .violInsert(violInsert), .forceLos(forceLos), .allOnes(allOnes),
    .posRail(posRail), .negRail(negRail)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp, input int step);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s step %0d rails actual=%b expected=%b", req, step, act, exp);
    end
  endtask

  function automatic bit patData(input int pat, input int t);
    case (pat)
      0: patData = ((t * 13) % 11) > 5;
      1: patData = (t % 24) < 2;
      2: patData = (t % 10) == 0;
      default: patData = (t % 3) != 0;
    endcase
  endfunction

  task automatic buildCase(input int pat, input bit subOff);
    int run = 0;
    for (int t = 0; t < STEPS; t++) begin
      dArr[t]    = patData(pat, t);
      losArr[t]  = (pat == 3) && t >= 20 && t <= 27;
      onesArr[t] = (pat == 3) && t >= 24 && t <= 35;
      violArr[t] = ((pat == 2) && t >= 12 && t <= 30) ||
                   ((pat == 0) && (t == 15 || t == 40)) ||
                   ((pat == 1) && t >= 30 && t <= 31) ||
                   ((pat == 3) && t == 22);
      if (dArr[t]) begin
        symArr[t] = S_MARK; run = 0;
      end else begin
        symArr[t] = S_ZERO;
        if (!subOff) begin
          run++;
          if (run == 8) begin
            // time order 0,0,0,V,B,0,V,B ending at t
            symArr[t-4] = S_V; symArr[t-3] = S_B;
            symArr[t-1] = S_V; symArr[t]   = S_B;
            run = 0;
          end
        end
      end
    end
  endtask

  task automatic doReset();
    bitEn = 0; violInsert = 0; forceLos = 0; allOnes = 0; dataIn = 0;
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {posRail, negRail}, 2'b00, -1);
    rstN = 1;
    @(negedge clk);
    check("R1", {posRail, negRail}, 2'b00, -1);
  endtask

  task automatic runCase(input int pat, input bit subOff, input bit single, input bit gapTest);
    bit lastPos = 0;
    bit armed = 0;
    bit prevViol = 0;
    buildCase(pat, subOff);
    substitutionOff = subOff;
    singleRail = single;
    doReset();
    for (int t = 0; t < STEPS; t++) begin
      bit pulse, pos, alt;
      int s;
      string req;
      bitEn = 1; dataIn = dArr[t];
      forceLos = losArr[t]; allOnes = onesArr[t]; violInsert = violArr[t];
      @(posedge clk);
      @(negedge clk);
      s = (t < DLY) ? S_NONE : symArr[t-DLY];
      pulse = 0; pos = 0; alt = 0;
      if (losArr[t]) begin
        req = "R6";
      end else if (onesArr[t] || s == S_MARK || s == S_B) begin
        alt = 1; pulse = 1;
        pos = armed ? lastPos : ~lastPos;
        if (armed) begin armed = 0; req = "R5"; end
        else req = onesArr[t] ? "R7" : (s == S_B ? "R4" : "R3");
        lastPos = pos;
      end else if (s == S_V) begin
        pulse = 1; pos = lastPos; req = "R4";
      end else begin
        req = (t < DLY) ? "R2" : "R3";
      end
      if (violArr[t] && !prevViol) armed = 1;
      prevViol = violArr[t];
      if (single && pulse) req = "R8";
      check(req, {posRail, negRail},
            single ? {pulse, 1'b0} : {pulse & pos, pulse & ~pos}, t);
      nChecks++;
      if (posRail && negRail) begin
        nFails++;
        $display("FAIL R9 step %0d rails actual=11 expected=not both high", t);
      end
      if (alt && !pulse) $display("unreachable");
    end
    if (gapTest) begin
      logic [1:0] held;
      held = {posRail, negRail};
      bitEn = 0;
      for (int g = 0; g < 6; g++) begin
        dataIn = g[0]; allOnes = g[1]; forceLos = g[2];
        @(posedge clk);
        @(negedge clk);
        check("R10", {posRail, negRail}, held, g);
      end
    end
    bitEn = 0;
  endtask

  initial begin
    for (int pat = 0; pat < 4; pat++)
      for (int subOff = 0; subOff < 2; subOff++)
        for (int single = 0; single < 2; single++)
          runCase(pat, subOff[0], single[0], pat == 1 && subOff == 0 && single == 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule